// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Monitor

This block watches the control pins of a two-bank synchronous DRAM and samples them on every rising clock edge. It turns each sample into one decoded command on a one-hot bus, along with the bank, the row or column address and the auto-precharge request. It keeps an open or precharged state for each bank. It follows the clock-enable pipeline so that suspend, power-down and self-refresh are recognised one clock after the pin changes. It also produces the data-side timing of a burst: a read output enable that obeys the two-clock DQM delay, and a write beat with a same-cycle mask.

The block is meant to sit beside a memory controller or a memory model, as a protocol monitor or as the front end of a command-driven model. It flags commands that are illegal for the current bank state. It separately flags a power-down entry made while a bank is still open. CAS latency (2 or 3) and burst length (1, 2, 4 or 8) are static configuration inputs.

Top module: `sdram_cmd_mon`

## Requirements
- R1: Pins are registered at each rising edge and the decoded command shows on `cmd_o` in the following cycle. With chip select high the command is deselect (bit 0). With the earlier CKE sample high and chip select low, {ras_ni,cas_ni,we_ni} selects: 000 mode set (bit 9), 001 refresh, 010 precharge, 011 activate (bit 2), 100 write (bit 4), 101 read (bit 3), 110 burst stop (bit 10), 111 no-op (bit 1). Exactly one bit of `cmd_o` is high.
- R2: A refresh decoded while the current CKE sample is high is auto refresh (bit 7). With the current sample low it is self-refresh entry (bit 8), and `sr_o` is high from the next cycle until the cycle after CKE is sampled high again.
- R3: On precharge, `addr_i[10]` high gives precharge-all (bit 6), which closes every bank the next cycle. Low gives single-bank precharge (bit 5) of the bank on `ba_i`.
- R4: For activate, `cmd_addr_o` carries the whole row address. For read and write it carries `addr_i[9:0]` zero-extended, and `auto_pre_o` copies `addr_i[10]`. `cmd_bank_o` gives the sampled bank, where 0 is the first bank and 1 the second.
- R5: A legal activate sets that bank's bit in `bank_open_o` from the next cycle. A legal single-bank precharge clears it.
- R6: `illegal_o` is high in the same cycle as the command in these cases: read, write or single precharge to a closed bank; activate to an open bank; mode set or either refresh while any bank is open. An illegal command changes no bank state and starts no burst.
- R7: When the earlier CKE sample is low, `cmd_o` shows suspend (bit 12) whatever the other pins are. Bank state and burst timing are then frozen.
- R8: A falling CKE sample (earlier high, current low) with no-op or deselect and no burst in flight is power-down entry (bit 11). `pd_o` is then high from the next cycle until the cycle after CKE is sampled high. Decoding resumes one cycle later.
- R9: `pd_viol_o` is high in the power-down entry cycle if any bank is open.
- R10: For a read shown in cycle t, with CL = 3 when `cas_lat_i` is 3 and 2 otherwise, and BL = 1 << `bl_code_i`, data beats fall in cycles t+CL to t+CL+BL-1. `rd_oe_o` is high in a beat cycle unless DQM was sampled high two cycles earlier.
- R11: For a write shown in cycle t, `wr_beat_o` is high in cycles t to t+BL-1. `wr_mask_o` is high in a beat cycle in which DQM is sampled high in that same cycle.
- R12: A burst stop in cycle s ends a write burst with no beat in cycle s. It ends a read burst with no beat from cycle s+CL on.
- R13: A legal read or write with `auto_pre_o` high closes its bank from cycle t+BL+1.
- R14: A mode set copies the sampled address into `mode_op_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| dqm_i | input | 1 | Data mask / output disable |
| ba_i | input | BA_W | Bank select |
| addr_i | input | ADDR_W | Address pins |
| cas_lat_i | input | 2 | CAS latency, 3 or else 2 |
| bl_code_i | input | 2 | Burst length code, BL = 1 << code |
| cmd_o | output | 13 | One-hot decoded command |
| cmd_bank_o | output | BA_W | Bank of the command |
| cmd_addr_o | output | ADDR_W | Row or column address |
| auto_pre_o | output | 1 | Auto-precharge on read or write |
| mode_op_o | output | ADDR_W | Last captured mode opcode |
| bank_open_o | output | NUM_BANKS | Per-bank open state |
| rd_oe_o | output | 1 | Read data output enable |
| wr_beat_o | output | 1 | Write data beat this cycle |
| wr_mask_o | output | 1 | Write beat is masked |
| pd_o | output | 1 | Power-down state |
| sr_o | output | 1 | Self-refresh state |
| illegal_o | output | 1 | Command illegal for bank state |
| pd_viol_o | output | 1 | Power-down entry with open bank |

## Verification
The properties assume a well-behaved controller on the pins. No activate or burst targets a bank while its auto-precharge is pending. A write does not start inside a read burst. `cas_lat_i` and `bl_code_i` do not change while a burst is in flight. The stimulus respects these assumptions: it precharges all banks between test groups, waits out each burst window in full before issuing the next command, and changes the configuration only while the block is idle. Sweeps over every pin code, both latencies and all burst lengths stay within those limits.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int NUM_CMD  = 13;
  localparam int CMD_DESEL = 0;
  localparam int CMD_NOP   = 1;
  localparam int CMD_ACT   = 2;
  localparam int CMD_RD    = 3;
  localparam int CMD_WR    = 4;
  localparam int CMD_PRE   = 5;
  localparam int CMD_PREA  = 6;
  localparam int CMD_REF   = 7;
  localparam int CMD_SREF  = 8;
  localparam int CMD_MRS   = 9;
  localparam int CMD_BST   = 10;
  localparam int CMD_PDN   = 11;
  localparam int CMD_SUSP  = 12;
  localparam int CL_MAX    = 3;
endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic               cke_prev_i,
  input  logic               cke_cur_i,
  input  logic               cs_ni,
  input  logic               ras_ni,
  input  logic               cas_ni,
  input  logic               we_ni,
  input  logic               all_bit_i,
  input  logic               busy_i,
  output logic [NUM_CMD-1:0] cmd_o
);
  // a falling CKE with an idle bus means power-down, otherwise clock suspend
  logic pd_req;
  assign pd_req = !cke_cur_i && !busy_i;

  always_comb begin
    cmd_o = '0;
    if (!cke_prev_i) begin
      cmd_o[CMD_SUSP] = 1'b1;
    end else if (cs_ni) begin
      if (pd_req) cmd_o[CMD_PDN]   = 1'b1;
      else        cmd_o[CMD_DESEL] = 1'b1;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000: cmd_o[CMD_MRS] = 1'b1;
        3'b001: if (cke_cur_i) cmd_o[CMD_REF] = 1'b1;
                else           cmd_o[CMD_SREF] = 1'b1;
        3'b010: if (all_bit_i) cmd_o[CMD_PREA] = 1'b1;
                else           cmd_o[CMD_PRE] = 1'b1;
        3'b011: cmd_o[CMD_ACT] = 1'b1;
        3'b100: cmd_o[CMD_WR]  = 1'b1;
        3'b101: cmd_o[CMD_RD]  = 1'b1;
        3'b110: cmd_o[CMD_BST] = 1'b1;
        default: if (pd_req) cmd_o[CMD_PDN] = 1'b1;
                 else        cmd_o[CMD_NOP] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank #(
  parameter int BA_W = 1,
  parameter int IDX  = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            act_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic            pre_i,
  input  logic            prea_i,
  input  logic            ap_close_i,
  input  logic [BA_W-1:0] ap_bank_i,
  output logic            open_o,
  output logic            illegal_o
);
  logic hit, ap_hit;
  assign hit    = (ba_i == BA_W'(IDX));
  assign ap_hit = ap_close_i && (ap_bank_i == BA_W'(IDX));

  assign illegal_o = hit && ((act_i && open_o) || ((rd_i || wr_i || pre_i) && !open_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
    end else if (en_i) begin
      if (prea_i || ap_hit || (pre_i && hit && open_o)) open_o <= 1'b0;
      else if (act_i && hit)                            open_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sdc_data_ctl.sv
module sdc_data_ctl
  import sdc_pkg::*;
#(
  parameter int BA_W      = 1,
  parameter int BL_CODE_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 rd_go_i,
  input  logic                 wr_go_i,
  input  logic                 bst_i,
  input  logic                 ap_req_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 dqm_i,
  input  logic                 cl3_i,
  input  logic [BL_CODE_W-1:0] bl_code_i,
  output logic                 rd_oe_o,
  output logic                 wr_beat_o,
  output logic                 wr_mask_o,
  output logic                 busy_o,
  output logic                 ap_close_o,
  output logic [BA_W-1:0]      ap_bank_o
);
  localparam int MAX_LOG = (1 << BL_CODE_W) - 1;
  localparam int CNT_W   = MAX_LOG + 1;

  logic [CNT_W-1:0]  bl, rd_cnt, wr_cnt, ap_cnt;
  logic [CL_MAX-1:0] rd_pipe, bst_pipe;
  logic [1:0]        dqm_pipe;
  logic              rd_start, bst_hit, rd_win, wr_win;

  assign bl       = CNT_W'(1) << bl_code_i;
  assign rd_start = cl3_i ? rd_pipe[CL_MAX-1]  : rd_pipe[CL_MAX-2];
  assign bst_hit  = cl3_i ? bst_pipe[CL_MAX-1] : bst_pipe[CL_MAX-2];
  assign rd_win   = rd_start || ((rd_cnt != '0) && !bst_hit);
  assign wr_win   = wr_go_i || ((wr_cnt != '0) && !bst_i && !rd_go_i);

  assign rd_oe_o    = rd_win && !dqm_pipe[1];
  assign wr_beat_o  = wr_win;
  assign wr_mask_o  = wr_win && dqm_i;
  assign busy_o     = (|rd_pipe) || (rd_cnt != '0) || (wr_cnt != '0);
  assign ap_close_o = (ap_cnt == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pipe   <= '0;
      bst_pipe  <= '0;
      dqm_pipe  <= '0;
      rd_cnt    <= '0;
      wr_cnt    <= '0;
      ap_cnt    <= '0;
      ap_bank_o <= '0;
    end else if (en_i) begin
      rd_pipe  <= {rd_pipe[CL_MAX-2:0], rd_go_i};
      bst_pipe <= {bst_pipe[CL_MAX-2:0], bst_i};
      dqm_pipe <= {dqm_pipe[0], dqm_i};

      if (rd_start)            rd_cnt <= bl - CNT_W'(1);
      else if (bst_hit)        rd_cnt <= '0;
      else if (rd_cnt != '0)   rd_cnt <= rd_cnt - CNT_W'(1);

      if (wr_go_i)                  wr_cnt <= bl - CNT_W'(1);
      else if (bst_i || rd_go_i)    wr_cnt <= '0;
      else if (wr_cnt != '0)        wr_cnt <= wr_cnt - CNT_W'(1);

      if ((rd_go_i || wr_go_i) && ap_req_i) begin
        ap_cnt    <= bl;
        ap_bank_o <= bank_i;
      end else if (ap_cnt != '0) begin
        ap_cnt <= ap_cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_mon.sv
module sdram_cmd_mon
  import sdc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  parameter int NUM_BANKS = 2,
  parameter int BL_CODE_W = 2,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic                 dqm_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           cas_lat_i,
  input  logic [BL_CODE_W-1:0] bl_code_i,
  output logic [NUM_CMD-1:0]   cmd_o,
  output logic [BA_W-1:0]      cmd_bank_o,
  output logic [ADDR_W-1:0]    cmd_addr_o,
  output logic                 auto_pre_o,
  output logic [ADDR_W-1:0]    mode_op_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 rd_oe_o,
  output logic                 wr_beat_o,
  output logic                 wr_mask_o,
  output logic                 pd_o,
  output logic                 sr_o,
  output logic                 illegal_o,
  output logic                 pd_viol_o
);
  logic              s_cke, s_cke_prev, s_cs_n, s_ras_n, s_cas_n, s_we_n, s_dqm;
  logic [BA_W-1:0]   s_ba;
  logic [ADDR_W-1:0] s_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_cke      <= 1'b1;
      s_cke_prev <= 1'b1;
      s_cs_n     <= 1'b1;
      s_ras_n    <= 1'b1;
      s_cas_n    <= 1'b1;
      s_we_n     <= 1'b1;
      s_dqm      <= 1'b0;
      s_ba       <= '0;
      s_addr     <= '0;
    end else begin
      s_cke      <= cke_i;
      s_cke_prev <= s_cke;
      s_cs_n     <= cs_ni;
      s_ras_n    <= ras_ni;
      s_cas_n    <= cas_ni;
      s_we_n     <= we_ni;
      s_dqm      <= dqm_i;
      s_ba       <= ba_i;
      s_addr     <= addr_i;
    end
  end

  logic en, busy, any_open, bank_bad, ap_close, rd_go, wr_go;
  logic [NUM_BANKS-1:0] bank_ill;
  logic [BA_W-1:0]      ap_bank;

  assign en = s_cke_prev;

  sdc_decode u_decode (
    .cke_prev_i (s_cke_prev),
    .cke_cur_i  (s_cke),
    .cs_ni      (s_cs_n),
    .ras_ni     (s_ras_n),
    .cas_ni     (s_cas_n),
    .we_ni      (s_we_n),
    .all_bit_i  (s_addr[AP_BIT]),
    .busy_i     (busy),
    .cmd_o      (cmd_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdc_bank #(.BA_W(BA_W), .IDX(b)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en),
      .ba_i       (s_ba),
      .act_i      (cmd_o[CMD_ACT]),
      .rd_i       (cmd_o[CMD_RD]),
      .wr_i       (cmd_o[CMD_WR]),
      .pre_i      (cmd_o[CMD_PRE]),
      .prea_i     (cmd_o[CMD_PREA]),
      .ap_close_i (ap_close),
      .ap_bank_i  (ap_bank),
      .open_o     (bank_open_o[b]),
      .illegal_o  (bank_ill[b])
    );
  end

  assign any_open = |bank_open_o;
  assign bank_bad = |bank_ill;
  assign rd_go    = cmd_o[CMD_RD] && !bank_bad;
  assign wr_go    = cmd_o[CMD_WR] && !bank_bad;

  sdc_data_ctl #(.BA_W(BA_W), .BL_CODE_W(BL_CODE_W)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .rd_go_i    (rd_go),
    .wr_go_i    (wr_go),
    .bst_i      (cmd_o[CMD_BST]),
    .ap_req_i   (s_addr[AP_BIT]),
    .bank_i     (s_ba),
    .dqm_i      (s_dqm),
    .cl3_i      (cas_lat_i == 2'd3),
    .bl_code_i  (bl_code_i),
    .rd_oe_o    (rd_oe_o),
    .wr_beat_o  (wr_beat_o),
    .wr_mask_o  (wr_mask_o),
    .busy_o     (busy),
    .ap_close_o (ap_close),
    .ap_bank_o  (ap_bank)
  );

  assign illegal_o = bank_bad ||
                     ((cmd_o[CMD_MRS] || cmd_o[CMD_REF] || cmd_o[CMD_SREF]) && any_open);
  assign pd_viol_o = cmd_o[CMD_PDN] && any_open;

  assign cmd_bank_o = s_ba;
  assign auto_pre_o = (cmd_o[CMD_RD] || cmd_o[CMD_WR]) && s_addr[AP_BIT];
  assign cmd_addr_o = (cmd_o[CMD_RD] || cmd_o[CMD_WR]) ?
                      {{(ADDR_W-COL_W){1'b0}}, s_addr[COL_W-1:0]} : s_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_op_o <= '0;
      pd_o      <= 1'b0;
      sr_o      <= 1'b0;
    end else begin
      if (cmd_o[CMD_MRS] && !any_open) mode_op_o <= s_addr;
      if (cmd_o[CMD_PDN])  pd_o <= 1'b1;
      else if (s_cke)      pd_o <= 1'b0;
      if (cmd_o[CMD_SREF] && !any_open) sr_o <= 1'b1;
      else if (s_cke)                   sr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cmd_mon_chk.sv
module sdram_cmd_mon_chk
  import sdc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 2,
  parameter int BA_W      = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_CMD-1:0]   cmd_o,
  input logic [BA_W-1:0]      cmd_bank_o,
  input logic [ADDR_W-1:0]    cmd_addr_o,
  input logic [ADDR_W-1:0]    mode_op_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic                 illegal_o,
  input logic                 pd_o,
  input logic                 sr_o
);
  AST_CMD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cmd_o) == 1); // R1

  AST_SREF_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_SREF] && !illegal_o) |=> sr_o); // R2

  AST_PREA_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CMD_PREA] |=> (bank_open_o == '0)); // R3

  AST_ACT_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_ACT] && !illegal_o) |=> (((bank_open_o >> $past(cmd_bank_o)) & 1) != 0)); // R5

  AST_ACT_OPEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_ACT] && illegal_o) |=> (((bank_open_o >> $past(cmd_bank_o)) & 1) != 0)); // R6

  AST_SUSP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CMD_SUSP] |=> $stable(bank_open_o)); // R7

  AST_PDN_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CMD_PDN] |=> pd_o); // R8

  AST_MODE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_MRS] && !illegal_o) |=> (mode_op_o == $past(cmd_addr_o))); // R14
endmodule

bind sdram_cmd_mon sdram_cmd_mon_chk #(
  .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BA_W(BA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_o       (cmd_o),
  .cmd_bank_o  (cmd_bank_o),
  .cmd_addr_o  (cmd_addr_o),
  .mode_op_o   (mode_op_o),
  .bank_open_o (bank_open_o),
  .illegal_o   (illegal_o),
  .pd_o        (pd_o),
  .sr_o        (sr_o)
);

// File: tb/sdram_cmd_mon_bench.sv
module sdram_cmd_mon_bench;
  localparam logic [2:0] OP_MRS = 3'b000, OP_REF = 3'b001, OP_PRE = 3'b010, OP_ACT = 3'b011;
  localparam logic [2:0] OP_WR  = 3'b100, OP_RD  = 3'b101, OP_BST = 3'b110, OP_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b0;
  logic [0:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [1:0]  cas_lat = 2'd2;
  logic [1:0]  bl_code = 2'd0;
  logic [12:0] cmd;
  logic [0:0]  cmd_bank;
  logic [11:0] cmd_addr, mode_op;
  logic [1:0]  bank_open;
  logic auto_pre, rd_oe, wr_beat, wr_mask, pd, sr, illegal, pd_viol;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_cmd_mon u_sdram_cmd_mon (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .dqm_i(dqm), .ba_i(ba), .addr_i(addr),
    .cas_lat_i(cas_lat), .bl_code_i(bl_code), .cmd_o(cmd), .cmd_bank_o(cmd_bank),
    .cmd_addr_o(cmd_addr), .auto_pre_o(auto_pre), .mode_op_o(mode_op),
    .bank_open_o(bank_open), .rd_oe_o(rd_oe), .wr_beat_o(wr_beat),
    .wr_mask_o(wr_mask), .pd_o(pd), .sr_o(sr), .illegal_o(illegal), .pd_viol_o(pd_viol)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pins(input logic [2:0] op, input logic csn, input logic ke,
                      input logic b, input logic [11:0] a, input logic dq);
    {ras_n, cas_n, we_n} = op;
    cs_n = csn; cke = ke; ba = b; addr = a; dqm = dq;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic issue(input logic [2:0] op, input logic b, input logic [11:0] a);
    pins(op, 1'b0, 1'b1, b, a, 1'b0);
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(OP_NOP, 1'b0, 12'h000);
  endtask

  function automatic int exp_bit(input logic [2:0] op, input logic csn, input logic ke);
    if (csn) return ke ? 0 : 11;
    case (op)
      OP_MRS: return 9;
      OP_REF: return ke ? 7 : 8;
      OP_PRE: return 5;
      OP_ACT: return 2;
      OP_WR:  return 4;
      OP_RD:  return 3;
      OP_BST: return 10;
      default: return ke ? 1 : 11;
    endcase
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    chk("reset R1 cmd", 32'(cmd), 32'h1);
    chk("reset R5 banks", 32'(bank_open), 0);
    chk("reset R10 rd_oe", 32'(rd_oe), 0);
    chk("reset R8 pd", 32'({pd, sr, illegal, pd_viol}), 0);

    // decode sweep over chip select, current CKE and pin code
    for (int cs_v = 0; cs_v < 2; cs_v++)
      for (int ke_v = 0; ke_v < 2; ke_v++)
        for (int op_v = 0; op_v < 8; op_v++) begin
          pins(3'(op_v), 1'(cs_v), 1'(ke_v), 1'b0, 12'h000, 1'b0);
          tick();
          chk($sformatf("R1 R2 R8 decode cs=%0d ke=%0d op=%0d", cs_v, ke_v, op_v),
              32'(cmd), 32'(1) << exp_bit(3'(op_v), 1'(cs_v), 1'(ke_v)));
          pins(OP_NOP, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0);
          tick();
          if (ke_v == 0) chk("R7 suspend after low CKE", 32'(cmd), 32'(1) << 12);
          tick();
          issue(OP_PRE, 1'b0, 12'h400);
          idle(1);
        end

    // bank tracking and illegal commands
    issue(OP_ACT, 1'b0, 12'h0AB);
    chk("R5 act legal", 32'(illegal), 0);
    idle(1);
    chk("R5 bank0 open", 32'(bank_open), 32'h1);
    issue(OP_ACT, 1'b0, 12'h0AB);
    chk("R6 act on open bank", 32'(illegal), 1);
    issue(OP_RD, 1'b1, 12'h000);
    chk("R6 read on closed bank", 32'(illegal), 1);
    issue(OP_PRE, 1'b1, 12'h000);
    chk("R6 precharge closed bank", 32'(illegal), 1);
    issue(OP_REF, 1'b0, 12'h000);
    chk("R6 refresh with open bank", 32'(illegal), 1);
    idle(3);
    chk("R6 no state change", 32'(bank_open), 32'h1);
    chk("R6 no burst from illegal read", 32'(rd_oe), 0);
    issue(OP_PRE, 1'b0, 12'h000);
    chk("R3 single precharge", 32'(cmd), 32'(1) << 5);
    idle(1);
    chk("R5 bank0 closed", 32'(bank_open), 0);
    issue(OP_ACT, 1'b0, 12'h001);
    issue(OP_ACT, 1'b1, 12'hABC);
    chk("R4 row address", 32'(cmd_addr), 32'hABC);
    chk("R4 bank", 32'(cmd_bank), 1);
    idle(1);
    chk("R5 both open", 32'(bank_open), 32'h3);
    issue(OP_PRE, 1'b0, 12'h400);
    chk("R3 precharge all", 32'(cmd), 32'(1) << 6);
    idle(1);
    chk("R3 all closed", 32'(bank_open), 0);

    // power-down and suspend
    pins(OP_NOP, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
    tick();
    chk("R8 pd entry", 32'(cmd), 32'(1) << 11);
    chk("R9 no violation when closed", 32'(pd_viol), 0);
    pins(OP_ACT, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
    tick();
    chk("R7 suspend ignores pins", 32'(cmd), 32'(1) << 12);
    chk("R8 pd state", 32'(pd), 1);
    pins(OP_ACT, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0);
    tick();
    chk("R8 exit delay", 32'(cmd), 32'(1) << 12);
    chk("R8 pd held in exit", 32'(pd), 1);
    issue(OP_NOP, 1'b0, 12'h000);
    chk("R8 pd cleared", 32'(pd), 0);
    chk("R8 decode resumes", 32'(cmd), 32'(1) << 1);
    chk("R7 act during suspend ignored", 32'(bank_open), 0);
    issue(OP_ACT, 1'b1, 12'h010);
    pins(OP_NOP, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0);
    tick();
    chk("R9 pd entry with open bank", 32'({cmd[11], pd_viol}), 32'h3);
    pins(OP_NOP, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0);
    tick();
    tick();
    issue(OP_PRE, 1'b0, 12'h400);
    issue(OP_REF, 1'b0, 12'h000);
    chk("R2 auto refresh", 32'(cmd), 32'(1) << 7);
    pins(OP_REF, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
    tick();
    chk("R2 self refresh entry", 32'(cmd), 32'(1) << 8);
    pins(OP_NOP, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
    tick();
    chk("R2 sr state", 32'(sr), 1);
    pins(OP_NOP, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0);
    tick();
    tick();
    chk("R2 sr exit", 32'(sr), 0);
    issue(OP_MRS, 1'b0, 12'h032);
    chk("R14 mrs decode", 32'(cmd), 32'(1) << 9);
    idle(1);
    chk("R14 opcode captured", 32'(mode_op), 32'h032);

    // read windows for each latency and burst length, DQM high in cycle 1
    for (int cl = 2; cl <= 3; cl++)
      for (int bc = 0; bc < 4; bc++) begin
        cas_lat = 2'(cl);
        bl_code = 2'(bc);
        issue(OP_ACT, 1'b0, 12'h123);
        issue(OP_RD, 1'b0, 12'h005);
        chk("R10 no data in cmd cycle", 32'(rd_oe), 0);
        for (int c = 1; c <= 13; c++) begin
          pins(OP_NOP, 1'b0, 1'b1, 1'b0, 12'h000, c == 1);
          tick();
          chk($sformatf("R10 read cl=%0d bl=%0d c=%0d", cl, 1 << bc, c), 32'(rd_oe),
              32'((c >= cl) && (c < cl + (1 << bc)) && (c != 3)));
        end
        issue(OP_PRE, 1'b0, 12'h400);
      end

    // write windows, DQM high in cycle 1
    cas_lat = 2'd2;
    for (int bc = 0; bc < 4; bc++) begin
      bl_code = 2'(bc);
      issue(OP_ACT, 1'b0, 12'h123);
      issue(OP_WR, 1'b0, 12'h006);
      chk("R11 beat in cmd cycle", 32'({wr_beat, wr_mask}), 32'h2);
      for (int c = 1; c <= 9; c++) begin
        pins(OP_NOP, 1'b0, 1'b1, 1'b0, 12'h000, c == 1);
        tick();
        chk($sformatf("R11 write bl=%0d c=%0d", 1 << bc, c), 32'({wr_beat, wr_mask}),
            32'({(c < (1 << bc)), (c < (1 << bc)) && (c == 1)}));
      end
      issue(OP_PRE, 1'b0, 12'h400);
    end

    // burst stop
    bl_code = 2'd3;
    issue(OP_ACT, 1'b0, 12'h111);
    issue(OP_RD, 1'b0, 12'h000);
    for (int c = 1; c <= 12; c++) begin
      if (c == 2) issue(OP_BST, 1'b0, 12'h000);
      else        issue(OP_NOP, 1'b0, 12'h000);
      chk($sformatf("R12 read stop c=%0d", c), 32'(rd_oe), 32'((c >= 2) && (c < 4)));
    end
    issue(OP_WR, 1'b0, 12'h000);
    for (int c = 1; c <= 9; c++) begin
      if (c == 3) issue(OP_BST, 1'b0, 12'h000);
      else        issue(OP_NOP, 1'b0, 12'h000);
      chk($sformatf("R12 write stop c=%0d", c), 32'(wr_beat), 32'(c < 3));
    end
    issue(OP_PRE, 1'b0, 12'h400);

    // auto-precharge
    bl_code = 2'd2;
    issue(OP_ACT, 1'b1, 12'h222);
    issue(OP_WR, 1'b1, 12'hC3A);
    chk("R4 column address", 32'(cmd_addr), 32'h03A);
    chk("R4 auto precharge flag", 32'(auto_pre), 1);
    for (int c = 1; c <= 6; c++) begin
      issue(OP_NOP, 1'b0, 12'h000);
      chk($sformatf("R13 write ap c=%0d", c), 32'(bank_open[1]), 32'(c <= 4));
    end
    bl_code = 2'd1;
    issue(OP_ACT, 1'b0, 12'h333);
    issue(OP_RD, 1'b0, 12'hFFF);
    chk("R4 read column", 32'({auto_pre, cmd_addr}), 32'h13FF);
    for (int c = 1; c <= 4; c++) begin
      issue(OP_NOP, 1'b0, 12'h000);
      chk($sformatf("R13 read ap c=%0d", c), 32'(bank_open[0]), 32'(c <= 2));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule